// File: doc/BRIEF.md
# Synchronizable Programmable Clock Divider

This block divides its input sample clock by an integer ratio N from 1 to 8. It produces two outputs. The first is a one-cycle clock-enable pulse at the start of every N-cycle period. The second is a divided clock level that is high for the first half of each period. A small write-only register port sets the ratio, requests the duty-cycle stabilizer, and selects how an external alignment strobe is handled. The stabilizer flag is driven high whenever N is not 1, whatever was programmed.

The alignment strobe returns the divider to its starting phase. When several dividers receive the same strobe, they all start their periods on the same input cycle. The strobe can act in one of two ways:
- On every rising edge.
- Only on the first rising edge after the alignment register is written. A new write arms the divider again.

A new ratio never cuts a period short. It takes effect at the next terminal count, or at once when a valid strobe arrives.

Top module: `sync_clk_divider`

## Requirements
- R1: Writing value v to address 0x101 sets N = v[2:0] + 1. Once N is active, `div_ce` is high for exactly one cycle in every N cycles.
- R2: With N = 1, `div_ce` is high on every cycle and `div_clk` is held high.
- R3: With N >= 2, `div_clk` is high for floor(N/2) cycles of each period, starting on the cycle where `div_ce` is high. It is low for the rest of the period.
- R4: `stab_en` equals bit 3 of address 0x101 OR (N != 1). It updates one cycle after the register write.
- R5: A newly written ratio first takes effect after the period in progress completes at the old length. No period is shortened.
- R6: Bit 1 of address 0x101's neighbour 0x100 enables alignment. With bit 1 = 1 and bit 2 = 0, every rising edge of `sync_in` restarts the divider: if `sync_in` is first sampled high at clock edge k, `div_ce` is high after edge k+2, and periods of N follow from there.
- R7: With bit 1 of 0x100 clear, `sync_in` edges have no effect on `div_ce`.
- R8: With bits 2 and 1 of 0x100 both set, only the first `sync_in` rising edge after a write to 0x100 restarts the divider. Later edges are ignored until 0x100 is written again.
- R9: A valid alignment edge loads the most recently written ratio immediately. The next period after the restart already has the new length.
- R10: While `rst` is high, `div_ce`, `div_clk` and `stab_en` are low. The ratio register resets to N = 1, and alignment resets to disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 9 | Register address (0x100 alignment, 0x101 ratio) |
| wdata | input | 8 | Register write data |
| sync_in | input | 1 | Asynchronous alignment strobe |
| div_ce | output | 1 | One-cycle pulse at the start of each divided period |
| div_clk | output | 1 | Divided clock level |
| stab_en | output | 1 | Duty-cycle stabilizer enable |

## Verification
The bench uses the default parameters: a 3-bit ratio field, a 9-bit address, 8-bit data and a two-flop strobe synchronizer. With these values every ratio from 1 to 8 can be swept, so the odd-N high time and the N = 1 pass-through are both measured. The 3-cycle strobe-to-pulse latency fits inside a 5-cycle period, so a restart can be told apart from the natural pulse. Ratio changes are tested both with and without a coincident strobe, to separate a terminal-count reload from a strobe reload.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int RATIO_W = 3;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   sync_en;
    logic   one_shot;
    logic   armed;
    ratio_t ratio_m1;
    logic   stab_req;
  } scd_cfg_t;
endpackage

// File: rtl/scd_sync_edge.sv
module scd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/scd_cfg_regs.sv
module scd_cfg_regs
  import scd_pkg::*;
#(
  parameter int                ADDR_W   = 9,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h100,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 9'h101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sync_rise,
  output scd_cfg_t          cfg,
  output logic              sync_go
);
  logic cfg_hit, div_hit;
  logic unused_wdata;

  assign cfg_hit = wr_en && (addr == CFG_ADDR);
  assign div_hit = wr_en && (addr == DIV_ADDR);
  assign unused_wdata = ^{wdata[DATA_W-1:RATIO_W+1], wdata[0]};

  assign sync_go = sync_rise && cfg.sync_en && (!cfg.one_shot || cfg.armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (cfg_hit) begin
        cfg.sync_en  <= wdata[1];
        cfg.one_shot <= wdata[2];
        cfg.armed    <= 1'b1;
      end else if (sync_go && cfg.one_shot) begin
        cfg.armed    <= 1'b0;
      end
      if (div_hit) begin
        cfg.ratio_m1 <= wdata[RATIO_W-1:0];
        cfg.stab_req <= wdata[RATIO_W];
      end
    end
  end
endmodule

// File: rtl/scd_div_core.sv
module scd_div_core #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_pend,
  input  logic               restart,
  output logic               div_ce,
  output logic               div_clk,
  output logic [RATIO_W-1:0] act_m1
);
  localparam int CW = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt, cnt_n, act_n;
  logic [CW-1:0]      n_next, hi_len;
  logic               tc, lvl_n;

  always_comb begin
    tc = (cnt == act_m1);
    if (restart || tc) begin
      cnt_n = '0;
      act_n = ratio_pend;
    end else begin
      cnt_n = cnt + RATIO_W'(1);
      act_n = act_m1;
    end
    n_next = CW'(act_n) + CW'(1);
    hi_len = n_next >> 1;
    lvl_n  = (act_n == '0) ? 1'b1 : (CW'(cnt_n) < hi_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_m1  <= '0;
      div_ce  <= 1'b0;
      div_clk <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      act_m1  <= act_n;
      div_ce  <= (cnt_n == '0);
      div_clk <= lvl_n;
    end
  end
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider
  import scd_pkg::*;
#(
  parameter int                ADDR_W      = 9,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 9'h100,
  parameter logic [ADDR_W-1:0] DIV_ADDR    = 9'h101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sync_in,
  output logic              div_ce,
  output logic              div_clk,
  output logic              stab_en
);
  scd_cfg_t cfg;
  logic     sync_rise, sync_go;
  ratio_t   act_m1;

  scd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sync_in), .rise(sync_rise)
  );

  scd_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR), .DIV_ADDR(DIV_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sync_rise(sync_rise), .cfg(cfg), .sync_go(sync_go)
  );

  scd_div_core #(.RATIO_W(RATIO_W)) u_core (
    .clk(clk), .rst(rst), .ratio_pend(cfg.ratio_m1), .restart(sync_go),
    .div_ce(div_ce), .div_clk(div_clk), .act_m1(act_m1)
  );

  always_ff @(posedge clk) begin
    if (rst) stab_en <= 1'b0;
    else     stab_en <= cfg.stab_req | (cfg.ratio_m1 != '0);
  end
endmodule

// File: rtl/scd_checker.sv
module scd_checker
  import scd_pkg::*;
#(
  parameter int                ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h100
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              div_ce,
  input logic              div_clk,
  input logic              stab_en,
  input ratio_t            act_m1,
  input ratio_t            ratio_m1,
  input logic              sync_go,
  input logic              one_shot,
  input logic              armed
);
  logic cfg_wr;
  assign cfg_wr = wr_en && (addr == CFG_ADDR);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (div_ce && act_m1 != '0 && !sync_go) |=> !div_ce);

  a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
    (act_m1 == '0) |=> (div_ce && div_clk));

  a_r3_level_at_start: assert property (@(posedge clk) disable iff (rst)
    div_ce |-> div_clk);

  a_r4_stab_forced: assert property (@(posedge clk) disable iff (rst)
    (ratio_m1 != '0) |=> stab_en);

  a_r6_restart_pulse: assert property (@(posedge clk) disable iff (rst)
    sync_go |=> div_ce);

  a_r8_disarm: assert property (@(posedge clk) disable iff (rst)
    (sync_go && one_shot && !cfg_wr) |=> !armed);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!div_ce && !div_clk && !stab_en));
endmodule

bind sync_clk_divider scd_checker #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .div_ce(div_ce), .div_clk(div_clk), .stab_en(stab_en),
  .act_m1(act_m1), .ratio_m1(cfg.ratio_m1), .sync_go(sync_go),
  .one_shot(cfg.one_shot), .armed(cfg.armed)
);

// File: tb/tb_sync_clk_divider.sv
module tb_sync_clk_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       sync_in = 1'b0;
  logic       div_ce, div_clk, stab_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sync_clk_divider dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sync_in(sync_in), .div_ce(div_ce), .div_clk(div_clk), .stab_en(stab_en)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_ce();
    for (int i = 0; i < 20; i++) begin
      tick();
      if (div_ce) return;
    end
  endtask

  // Strobe starting now (just after edge P0); returns just after edge P3.
  task automatic strobe_to_p3();
    sync_in = 1'b1;
    tick();
    tick();
    sync_in = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check(!div_ce && !div_clk && !stab_en, "R10 outputs in reset", {div_ce, div_clk, stab_en}, 0);
    rst = 1'b0;
    tick();
    check(div_ce, "R10 reset ratio is 1", div_ce, 1);
  endtask

  task automatic t_ratio(input int n);
    int cyc, highs;
    wr(9'h101, 8'(n - 1));
    wait_ce(); wait_ce();
    highs = div_clk ? 1 : 0;
    cyc = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      cyc++;
      if (div_ce) break;
      if (div_clk) highs++;
    end
    check(cyc == n, "R1 period length", cyc, n);
    if (n == 1) begin
      tick();
      check(div_ce && div_clk, "R2 pass-through", {div_ce, div_clk}, 3);
    end else begin
      check(highs == n / 2, "R3 high time", highs, n / 2);
    end
  endtask

  task automatic t_stab();
    wr(9'h101, 8'h00); tick();
    check(stab_en == 1'b0, "R4 stab off at N=1", stab_en, 0);
    wr(9'h101, 8'h08);
    check(stab_en == 1'b0, "R4 one-cycle delay", stab_en, 0);
    tick();
    check(stab_en == 1'b1, "R4 stab requested", stab_en, 1);
    wr(9'h101, 8'h02); tick();
    check(stab_en == 1'b1, "R4 stab forced N=3", stab_en, 1);
  endtask

  task automatic t_ratio_change();
    wr(9'h101, 8'h03);
    wait_ce(); wait_ce();
    wr(9'h101, 8'h06);  // write lands at P1
    tick(); tick();     // P3
    check(!div_ce, "R5 old period intact", div_ce, 0);
    tick();             // P4
    check(div_ce, "R5 old period end", div_ce, 1);
    for (int i = 0; i < 6; i++) tick();
    check(!div_ce, "R5 new period not early", div_ce, 0);
    tick();
    check(div_ce, "R5 new period length 7", div_ce, 1);
  endtask

  task automatic t_sync_every();
    wr(9'h101, 8'h04);
    wr(9'h100, 8'h02);
    wait_ce(); wait_ce();
    strobe_to_p3();
    check(div_ce, "R6 restart at k+2", div_ce, 1);
    for (int i = 0; i < 5; i++) tick();
    check(div_ce, "R6 period after restart", div_ce, 1);
    tick();
    strobe_to_p3();     // strobe started one cycle after a pulse
    check(div_ce, "R6 restart other phase", div_ce, 1);
    for (int i = 0; i < 5; i++) tick();
    check(div_ce, "R6 second realigned period", div_ce, 1);
  endtask

  task automatic t_sync_off();
    wr(9'h100, 8'h00);
    wait_ce(); wait_ce();
    strobe_to_p3();
    check(!div_ce, "R7 strobe ignored", div_ce, 0);
    tick(); tick();
    check(div_ce, "R7 natural pulse kept", div_ce, 1);
  endtask

  task automatic t_one_shot();
    wr(9'h100, 8'h06);
    wait_ce(); wait_ce();
    strobe_to_p3();
    check(div_ce, "R8 first strobe acts", div_ce, 1);
    for (int i = 0; i < 6; i++) tick();
    wait_ce();
    strobe_to_p3();
    check(!div_ce, "R8 second strobe ignored", div_ce, 0);
    tick(); tick();
    check(div_ce, "R8 phase unchanged", div_ce, 1);
    wr(9'h100, 8'h06);
    wait_ce();
    strobe_to_p3();
    check(div_ce, "R8 rearmed by write", div_ce, 1);
  endtask

  task automatic t_sync_ratio();
    wr(9'h100, 8'h02);
    wr(9'h101, 8'h03);
    wait_ce(); wait_ce();
    wr_en = 1'b1; addr = 9'h101; wdata = 8'h06; sync_in = 1'b1;
    tick();             // P1
    wr_en = 1'b0;
    tick();             // P2
    sync_in = 1'b0;
    tick();             // P3
    check(div_ce, "R9 restart", div_ce, 1);
    for (int i = 0; i < 4; i++) tick();
    check(!div_ce, "R9 old length not used", div_ce, 0);
    tick(); tick(); tick();
    check(div_ce, "R9 new length 7 at once", div_ce, 1);
  endtask

  initial begin
    t_reset();
    for (int n = 1; n <= 8; n++) t_ratio(n);
    t_stab();
    t_ratio_change();
    t_sync_every();
    t_sync_off();
    t_one_shot();
    t_sync_ratio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule